// File: doc/BRIEF.md
# Debug exception entry controller

This block performs the state update a processor core makes when it enters a debug exception. On a raise request it compares the interrupt-level field of the current status word with a fixed debug level. The request is taken only when the core's current level is lower than the debug level. A taken request is handled in one clock edge. The block records the cause code, saves the PC and the status word into save slots chosen by the debug level, and builds the new status word. It then pulses a taken strobe together with a debug exception code, which the core's exception sequencer acts on.

The interrupt-level field is the 4-bit field at bits [3:0] of the status word. The exception-mode flag sits at bit `EXCM_BIT`. The PC save file has one slot for each level from 1 to `NUM_LVL`. The status save file has one slot for each level from 2 to `NUM_LVL`. A register-select read port makes every slot and the cause register visible from outside.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: While reset is asserted, and after reset is released, the cause register and every save slot read zero, `taken_o` is 0 and `exc_code_o` is 0.
- R2: When `req_i` is high at a rising edge and `ps_i[3:0]` is less than `DBG_LVL`, `taken_o` is 1 for the following cycle. Each qualifying edge gives one cycle of `taken_o`.
- R3: When `req_i` is low, or `ps_i[3:0]` is at least `DBG_LVL`, no state changes, and `taken_o` is 0 in the following cycle.
- R4: On a taken request, the cause register captures `cause_i`.
- R5: On a taken request, the PC save slot for level `DBG_LVL` captures `pc_i`. The slot index is the level minus 1.
- R6: On a taken request, the status save slot for level `DBG_LVL` captures `ps_i`. The slot index is the level minus 2.
- R7: While `taken_o` is 1, `ps_o` equals the captured `ps_i` with two changes: bits [3:0] are replaced by `DBG_LVL`, and bit `EXCM_BIT` (default 4) is set.
- R8: `exc_code_o` is 4'd9 (debug exception) while `taken_o` is 1, and 4'd0 otherwise.
- R9: The read port decodes `rd_sel_i` as follows. When bit 3 is 0, value 0 selects the zero-extended cause register and values 1 to 7 select the PC slot of that level. When bit 3 is 1, bits [2:0] = L with L from 2 to 7 select the status slot of level L, and L of 0 or 1 reads zero.
- R10: A taken request changes no save slot other than the two belonging to `DBG_LVL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Debug exception raise request |
| pc_i | input | PC_W | PC of the faulting instruction |
| cause_i | input | CAUSE_W | Debug cause code |
| ps_i | input | PS_W | Current status word |
| rd_sel_i | input | 4 | Read-port register select |
| taken_o | output | 1 | One-cycle pulse for each taken request |
| ps_o | output | PS_W | Rewritten status word, valid with `taken_o` |
| exc_code_o | output | 4 | Exception code signalled to the core |
| rd_data_o | output | max(PC_W,PS_W) | Read-port data |

## Verification
The assertions check the following on every cycle:
- the take decision against the level comparison, in both directions;
- the one-cycle pulse;
- the fields of the rewritten status word;
- the pairing of the exception code with the strobe.

The bench scenarios cover what only the stored state can show. They sweep every interrupt level, including the boundary at the debug level. After each request, every read selector is compared against a model of the save files. This shows that the correct slot was written, that all other slots kept their contents, and that ignored requests left the cause register and the slots untouched.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  localparam int ILVL_W = 4;
  localparam int LVL_W  = 3;

  typedef enum logic [3:0] {
    EXC_NONE  = 4'd0,
    EXC_DEBUG = 4'd9
  } exc_code_e;
endpackage

// File: rtl/dbg_entry_gate.sv
module dbg_entry_gate
  import dbg_entry_pkg::*;
#(
  parameter int DBG_LVL = 6
) (
  input  logic              req_i,
  input  logic [ILVL_W-1:0] ilvl_i,
  output logic              take_o
);
  localparam logic [ILVL_W-1:0] DbgLvl = ILVL_W'(DBG_LVL);

  assign take_o = req_i && (ilvl_i < DbgLvl);
endmodule

// File: rtl/dbg_ps_rewrite.sv
module dbg_ps_rewrite
  import dbg_entry_pkg::*;
#(
  parameter int PS_W     = 32,
  parameter int DBG_LVL  = 6,
  parameter int EXCM_BIT = 4
) (
  input  logic [PS_W-1:0] ps_i,
  output logic [PS_W-1:0] ps_o
);
  localparam logic [ILVL_W-1:0] DbgLvl = ILVL_W'(DBG_LVL);

  always_comb begin
    ps_o               = ps_i;
    ps_o[ILVL_W-1:0]   = DbgLvl;
    ps_o[EXCM_BIT]     = 1'b1;
  end
endmodule

// File: rtl/dbg_save_file.sv
module dbg_save_file
  import dbg_entry_pkg::*;
#(
  parameter int W        = 32,
  parameter int DEPTH    = 7,
  parameter int BASE_LVL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [LVL_W-1:0] wr_lvl_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [LVL_W-1:0] rd_lvl_i,
  output logic [W-1:0]     rdata_o
);
  logic [W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
      end else if (we_i && wr_lvl_i == LVL_W'(g + BASE_LVL)) begin
        slot_q[g] <= wdata_i;
      end
    end
  end

  // Out-of-range levels read zero
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (rd_lvl_i == LVL_W'(k + BASE_LVL)) rdata_o = slot_q[k];
    end
  end
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PS_W     = 32,
  parameter int CAUSE_W  = 6,
  parameter int NUM_LVL  = 7,
  parameter int DBG_LVL  = 6,
  parameter int EXCM_BIT = 4
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  req_i,
  input  logic [PC_W-1:0]                       pc_i,
  input  logic [CAUSE_W-1:0]                    cause_i,
  input  logic [PS_W-1:0]                       ps_i,
  input  logic [3:0]                            rd_sel_i,
  output logic                                  taken_o,
  output logic [PS_W-1:0]                       ps_o,
  output logic [3:0]                            exc_code_o,
  output logic [(PC_W > PS_W ? PC_W : PS_W)-1:0] rd_data_o
);
  localparam int DATA_W = (PC_W > PS_W) ? PC_W : PS_W;
  localparam logic [LVL_W-1:0] WrLvl = LVL_W'(DBG_LVL);

  logic               take;
  logic [PS_W-1:0]    ps_new;
  logic               taken_q;
  logic [PS_W-1:0]    ps_q;
  logic [CAUSE_W-1:0] cause_q;
  logic [PC_W-1:0]    epc_rd;
  logic [PS_W-1:0]    eps_rd;

  dbg_entry_gate #(.DBG_LVL(DBG_LVL)) i_gate (
    .req_i  (req_i),
    .ilvl_i (ps_i[ILVL_W-1:0]),
    .take_o (take)
  );

  dbg_ps_rewrite #(.PS_W(PS_W), .DBG_LVL(DBG_LVL), .EXCM_BIT(EXCM_BIT)) i_ps (
    .ps_i (ps_i),
    .ps_o (ps_new)
  );

  // PC save slots: levels 1..NUM_LVL
  dbg_save_file #(.W(PC_W), .DEPTH(NUM_LVL), .BASE_LVL(1)) i_epc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (take),
    .wr_lvl_i (WrLvl),
    .wdata_i  (pc_i),
    .rd_lvl_i (rd_sel_i[2:0]),
    .rdata_o  (epc_rd)
  );

  // Status save slots: levels 2..NUM_LVL
  dbg_save_file #(.W(PS_W), .DEPTH(NUM_LVL - 1), .BASE_LVL(2)) i_eps (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (take),
    .wr_lvl_i (WrLvl),
    .wdata_i  (ps_i),
    .rd_lvl_i (rd_sel_i[2:0]),
    .rdata_o  (eps_rd)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_q <= 1'b0;
      ps_q    <= '0;
      cause_q <= '0;
    end else begin
      taken_q <= take;
      if (take) begin
        ps_q    <= ps_new;
        cause_q <= cause_i;
      end
    end
  end

  assign taken_o    = taken_q;
  assign ps_o       = ps_q;
  assign exc_code_o = taken_q ? EXC_DEBUG : EXC_NONE;

  always_comb begin
    if (rd_sel_i[3]) begin
      rd_data_o = DATA_W'(eps_rd);
    end else if (rd_sel_i[2:0] == '0) begin
      rd_data_o = DATA_W'(cause_q);
    end else begin
      rd_data_o = DATA_W'(epc_rd);
    end
  end
endmodule

// File: rtl/dbg_entry_chk.sv
module dbg_entry_chk #(
  parameter int PS_W     = 32,
  parameter int DBG_LVL  = 6,
  parameter int EXCM_BIT = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_i,
  input logic [PS_W-1:0] ps_i,
  input logic            taken_o,
  input logic [PS_W-1:0] ps_o,
  input logic [3:0]      exc_code_o
);
  localparam logic [3:0] DbgLvl = 4'(DBG_LVL);

  // R2
  take_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ps_i[3:0] < DbgLvl) |=> taken_o);

  // R3
  no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && ps_i[3:0] < DbgLvl) |=> !taken_o);

  // R7
  ps_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (ps_o[3:0] == DbgLvl && ps_o[EXCM_BIT]));

  // R7
  ps_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> ps_o[PS_W-1:EXCM_BIT+1] == $past(ps_i[PS_W-1:EXCM_BIT+1]));

  // R8
  code_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> exc_code_o == 4'd9);

  // R8
  code_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> exc_code_o == 4'd0);
endmodule

bind dbg_entry_ctrl dbg_entry_chk #(
  .PS_W(PS_W), .DBG_LVL(DBG_LVL), .EXCM_BIT(EXCM_BIT)
) i_dbg_entry_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .ps_i       (ps_i),
  .taken_o    (taken_o),
  .ps_o       (ps_o),
  .exc_code_o (exc_code_o)
);

// File: tb/test_dbg_entry_ctrl.sv
module test_dbg_entry_ctrl;
  localparam int DBG = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic [5:0]  cause_i = '0;
  logic [31:0] ps_i = '0;
  logic [3:0]  rd_sel_i = '0;
  logic        taken_o;
  logic [31:0] ps_o;
  logic [3:0]  exc_code_o;
  logic [31:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_cause;
  logic [31:0] m_epc [8];
  logic [31:0] m_eps [8];

  always #2 clk_i = ~clk_i;

  dbg_entry_ctrl i_dbg_entry_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .pc_i(pc_i),
    .cause_i(cause_i), .ps_i(ps_i), .rd_sel_i(rd_sel_i),
    .taken_o(taken_o), .ps_o(ps_o), .exc_code_o(exc_code_o),
    .rd_data_o(rd_data_o)
  );

  task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [3:0] sel);
    if (sel[3]) return (sel[2:0] >= 3'd2) ? m_eps[sel[2:0]] : 32'h0;
    if (sel[2:0] == 3'd0) return m_cause;
    return m_epc[sel[2:0]];
  endfunction

  // R9 R10: all selectors against the model
  task automatic check_all_regs(string rq);
    for (int s = 0; s < 16; s++) begin
      rd_sel_i = 4'(s);
      #1;
      check(rq, rd_data_o, model_rd(4'(s)));
    end
  endtask

  task automatic raise(logic [31:0] pc, logic [5:0] cs, logic [31:0] ps);
    bit tk;
    @(negedge clk_i);
    req_i = 1'b1; pc_i = pc; cause_i = cs; ps_i = ps;
    tk = (ps[3:0] < 4'(DBG));
    @(posedge clk_i);
    #1;
    req_i = 1'b0;
    if (tk) begin
      m_cause = 32'(cs);
      m_epc[DBG] = pc;
      m_eps[DBG] = ps;
      check("R2", 32'(taken_o), 32'd1);
      check("R7", ps_o, (ps & ~32'h1F) | 32'h10 | 32'(DBG));
      check("R8", 32'(exc_code_o), 32'd9);
    end else begin
      check("R3", 32'(taken_o), 32'd0);
      check("R8", 32'(exc_code_o), 32'd0);
    end
    @(posedge clk_i);
    #1;
    check("R2 pulse", 32'(taken_o), 32'd0);
  endtask

  initial begin
    m_cause = '0;
    for (int i = 0; i < 8; i++) begin m_epc[i] = '0; m_eps[i] = '0; end
    #5;
    check("R1", 32'(taken_o), 32'd0);
    check("R1", 32'(exc_code_o), 32'd0);
    check_all_regs("R1");
    rst_ni = 1'b1;
    repeat (2) @(posedge clk_i);
    #1;
    check("R1", 32'(taken_o), 32'd0);

    // Sweep every interrupt level, both sides of the debug level
    for (int lv = 0; lv < 16; lv++) begin
      logic [31:0] ps;
      ps = {16'hA5C3 ^ 16'(lv * 16'h1111), 12'(lv * 37), 4'(lv)};
      raise(32'h1000_0000 + 32'(lv * 4) ^ 32'h0F0F_0000, 6'(lv * 5 + 3), ps);
      check_all_regs(lv < DBG ? "R4 R5 R6 R10" : "R3");
    end

    // Request low with a low level: nothing happens
    @(negedge clk_i);
    pc_i = 32'hDEAD_BEEF; cause_i = 6'h3F; ps_i = 32'h0;
    @(posedge clk_i); #1;
    check("R3 idle", 32'(taken_o), 32'd0);
    check_all_regs("R3");

    // Back-to-back requests at level DBG-1 (boundary) and level 0
    @(negedge clk_i);
    req_i = 1'b1; pc_i = 32'h1111_2222; cause_i = 6'h15; ps_i = 32'hFFFF_FFE5;
    @(posedge clk_i); #1;
    check("R2 b2b", 32'(taken_o), 32'd1);
    check("R7 b2b", ps_o, 32'hFFFF_FFF6);
    @(negedge clk_i);
    pc_i = 32'h3333_4444; cause_i = 6'h2A; ps_i = 32'h0000_0100;
    @(posedge clk_i); #1;
    req_i = 1'b0;
    check("R2 b2b", 32'(taken_o), 32'd1);
    check("R7 b2b", ps_o, 32'h0000_0116);
    m_cause = 32'h2A; m_epc[DBG] = 32'h3333_4444; m_eps[DBG] = 32'h0000_0100;
    @(posedge clk_i); #1;
    check("R2 b2b end", 32'(taken_o), 32'd0);
    check_all_regs("R4 R5 R6 R9");

    // Request exactly at the debug level is ignored
    raise(32'h5555_6666, 6'h01, 32'h0000_0006);
    check_all_regs("R3 boundary");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule